// File: doc/BRIEF.md
# First-Order Low-Pass Filter in 2.14 Fixed Point

This block smooths a stream of signed samples with a one-pole, one-zero recursive low-pass section. Samples and coefficients are 16-bit two's complement numbers with two bits above the binary point (one of them the sign), so they cover -2 up to just below +2 in steps of 2^-14. Each time the input strobe is high, the block forms the sum of the new sample and the previous sample, scales it by a feed-forward coefficient, adds the previous output scaled by a feedback coefficient, and emits the result two cycles later with a valid flag.

The two coefficients are written through a minimal write port: a select bit picks the feed-forward term (the shared numerator weight of the section) or the feedback term (the negated denominator weight). A typical use runs the filter at a 100 kHz sample rate with coefficients designed for a normalised cutoff of 0.01, giving a corner near 500 Hz. Next to the signed result the block also presents an 8-bit unsigned code for a DAC, formed by keeping the top bits of the output and adding half scale, so a signal with no DC sits in the middle of the converter range.

Intermediate sums and the output clamp at the 16-bit limits instead of wrapping. The pipeline accepts a new sample on every cycle.

Top module: `lp1_filter`

## Requirements
- R1: After a synchronous active-low reset, out_valid is 0, out_sample is 0, out_dac is 128, both coefficients are 0 and both history values (previous input, previous output) are 0.
- R2: For a strobed input x, with s = clamp16(x + x_prev), the output is y = clamp16(floor(c_ff*s / 2^14) + floor(c_fb*y_prev / 2^14)), all values signed 2.14 two's complement; afterwards x_prev = x and y_prev = y.
- R3: The sum x + x_prev is clamped to [-32768, 32767] before it is multiplied, so two large samples of the same sign never wrap.
- R4: The final output is clamped to [-32768, 32767].
- R5: Cycles with in_valid low change neither history value nor out_sample; out_sample holds the last result.
- R6: out_valid is high in exactly the second cycle after each cycle in which in_valid is high and low otherwise; strobes on consecutive cycles are all accepted.
- R7: out_dac = clamp((out_sample >>> 6) + 128, 0, 255), an 8-bit unsigned code.
- R8: A write with cfg_we high and cfg_sel = 0 loads the feed-forward coefficient c_ff from cfg_wdata, cfg_sel = 1 loads the feedback coefficient c_fb; the new value applies to every sample strobed in the same cycle as the write or later.
- R9: A reset in the middle of a stream clears the history, so the first result afterwards depends only on the new input.
- R10: With c_ff = 250 and c_fb = 15885 (cutoff 0.01 of Nyquist), a constant input of 8192 settles to within 64 of 8192 and an input alternating between +8192 and -8192 decays to within 64 of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_sel | input | 1 | Coefficient select: 0 feed-forward, 1 feedback |
| cfg_wdata | input | 16 | Coefficient value, signed 2.14 |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Input sample, signed 2.14 |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_sample | output | 16 | Filtered sample, signed 2.14 |
| out_dac | output | 8 | Offset-binary DAC code of out_sample |

## Verification
The hardest situation to reach is a coefficient write landing in the same cycle as a strobe while the previous sample is still in its second stage, because that sample must use the old coefficient and the new one must use the new value. The random phase issues strobes and writes independently on each cycle with back-to-back strobes allowed, so this overlap occurs many times, and the bench model applies the write before computing the sample of that cycle. Clamping of the input sum is forced by directed pairs of full-scale samples with a half-scale feed-forward coefficient, where wrapping would flip the sign of the result.

// File: rtl/lp1_pkg.sv
// Shared constants for the first-order low-pass filter.
// Assumes a 2.14 signed format: one sign bit, one integer bit, 14 fraction bits.
package lp1_pkg;
    localparam int SMP_W   = 16;  // sample and coefficient width
    localparam int FRAC_W  = 14;  // fraction bits
    localparam int DAC_W   = 8;   // DAC code width
    localparam int NCOEF   = 2;   // number of coefficients
    localparam int SEL_W   = $clog2(NCOEF);
    localparam int COEF_FF = 0;   // index of feed-forward weight
    localparam int COEF_FB = 1;   // index of feedback weight
endpackage

// File: rtl/lp1_coefs.sv
// Coefficient registers for the low-pass section.
// A write lands at the clock edge where cfg_we is high; synchronous reset clears all.
module lp1_coefs #(
    parameter int DW    = 16,
    parameter int NC    = 2,
    parameter int SW    = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [SW-1:0]          sel,
    input  logic [DW-1:0]          wdata,
    output logic [NC-1:0][DW-1:0]  coef
);
    logic [NC-1:0][DW-1:0] coef_q;

    for (genvar i = 0; i < NC; i++) begin : g_reg
        // holds coefficient i, loaded when selected
        always_ff @(posedge clk) begin
            if (!rst_n)
                coef_q[i] <= '0;
            else if (we && sel == SW'(i))
                coef_q[i] <= wdata;
        end
    end

    assign coef = coef_q;

    // R8: a write is visible in the selected register on the next cycle
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> coef_q[$past(sel)] == $past(wdata));
endmodule

// File: rtl/lp1_core.sv
// Two-stage datapath of the first-order section.
// Stage 1 forms the clamped sum of the new and previous input; stage 2 forms
// the two rescaled products, adds and clamps them, and updates the output history.
// Assumes coefficients and samples share the same fixed-point format.
module lp1_core #(
    parameter int DW   = 16,
    parameter int FRAC = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [DW-1:0] c_ff,
    input  logic signed [DW-1:0] c_fb,
    output logic                 y_valid,
    output logic signed [DW-1:0] y_out
);
    localparam int PW = 2 * DW;
    localparam logic signed [DW-1:0] S_MAX = DW'((2 ** (DW - 1)) - 1);
    localparam logic signed [DW-1:0] S_MIN = DW'(-(2 ** (DW - 1)));
    localparam logic signed [PW:0]   A_MAX = (PW + 1)'((2 ** (DW - 1)) - 1);
    localparam logic signed [PW:0]   A_MIN = (PW + 1)'(-(2 ** (DW - 1)));

    logic signed [DW-1:0] x_prev;
    logic signed [DW-1:0] sum_q;
    logic                 v1_q;
    logic signed [DW-1:0] y_prev;
    logic                 v2_q;

    logic signed [DW:0]   raw_sum;
    logic signed [DW-1:0] sum_sat;
    logic signed [PW-1:0] prod_ff, prod_fb, sh_ff, sh_fb;
    logic signed [PW:0]   acc;
    logic signed [DW-1:0] y_sat;

    // widen and add the new and previous input, clamp on overflow
    always_comb begin
        raw_sum = {x_in[DW-1], x_in} + {x_prev[DW-1], x_prev};
        if (raw_sum[DW] != raw_sum[DW-1])
            sum_sat = raw_sum[DW] ? S_MIN : S_MAX;
        else
            sum_sat = raw_sum[DW-1:0];
    end

    // stage 1: register the sum and remember the input
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_prev <= '0;
            sum_q  <= '0;
            v1_q   <= 1'b0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                x_prev <= x_in;
                sum_q  <= sum_sat;
            end
        end
    end

    // products rescaled by an arithmetic right shift, summed and clamped
    always_comb begin
        prod_ff = c_ff * sum_q;
        prod_fb = c_fb * y_prev;
        sh_ff   = prod_ff >>> FRAC;
        sh_fb   = prod_fb >>> FRAC;
        acc     = {sh_ff[PW-1], sh_ff} + {sh_fb[PW-1], sh_fb};
        if (acc > A_MAX)
            y_sat = S_MAX;
        else if (acc < A_MIN)
            y_sat = S_MIN;
        else
            y_sat = acc[DW-1:0];
    end

    // stage 2: register the result, which is also the output history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_prev <= '0;
            v2_q   <= 1'b0;
        end else begin
            v2_q <= v1_q;
            if (v1_q)
                y_prev <= y_sat;
        end
    end

    assign y_valid = v2_q;
    assign y_out   = y_prev;

    // R3: two positive inputs never give a negative sum
    a_r3_no_wrap_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x_in > 0 && x_prev > 0) |=> sum_q > 0);
    // R3: two negative inputs never give a non-negative sum
    a_r3_no_wrap_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x_in < 0 && x_prev < 0) |=> sum_q < 0);
    // R5: history of the input is untouched without a strobe
    a_r5_xprev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(x_prev));
endmodule

// File: rtl/lp1_dac.sv
// Converts a signed fixed-point sample to an offset-binary DAC code.
// Keeps the top bits of the sample, adds half scale and clamps to the code range.
module lp1_dac #(
    parameter int DW    = 16,
    parameter int DAC_W = 8
) (
    input  logic signed [DW-1:0]  y,
    output logic [DAC_W-1:0]      code
);
    localparam int SH = DW - DAC_W - 2;
    localparam int TW = DW - SH + 1;
    localparam logic signed [TW-1:0] OFFS = TW'(2 ** (DAC_W - 1));
    localparam logic signed [TW-1:0] CMAX = TW'((2 ** DAC_W) - 1);

    logic signed [TW-1:0] top;
    logic signed [TW-1:0] shifted;

    // shift, recentre and clamp
    always_comb begin
        shifted = $signed(TW'(y >>> SH));
        top     = shifted + OFFS;
        if (top < 0)
            code = '0;
        else if (top > CMAX)
            code = '1;
        else
            code = top[DAC_W-1:0];
    end
endmodule

// File: rtl/lp1_filter.sv
// First-order low-pass filter, top level.
// Coefficient registers feed the two-stage datapath; the DAC mapper follows the
// registered result. Assumes in_valid is meaningful only while rst_n is high.
module lp1_filter
    import lp1_pkg::*;
#(
    parameter int DW    = SMP_W,
    parameter int FRAC  = FRAC_W,
    parameter int DACW  = DAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_sample,
    output logic             out_valid,
    output logic [DW-1:0]    out_sample,
    output logic [DACW-1:0]  out_dac
);
    logic [NCOEF-1:0][DW-1:0] coef;
    logic signed [DW-1:0]     y_s;
    logic [1:0]               age;

    lp1_coefs #(.DW(DW), .NC(NCOEF), .SW(SEL_W)) u_coefs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .coef  (coef)
    );

    lp1_core #(.DW(DW), .FRAC(FRAC)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .x_in     ($signed(in_sample)),
        .c_ff     ($signed(coef[COEF_FF])),
        .c_fb     ($signed(coef[COEF_FB])),
        .y_valid  (out_valid),
        .y_out    (y_s)
    );

    lp1_dac #(.DW(DW), .DAC_W(DACW)) u_dac (
        .y    (y_s),
        .code (out_dac)
    );

    assign out_sample = y_s;

    // cycles since reset, saturating, used to qualify the checks below
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (age != 2'd2)
            age <= age + 2'd1;
    end

    // R1: the first cycle after reset shows an idle, zero output
    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && out_sample == '0));
    // R6: result strobe follows the input strobe by two cycles
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));
    // R5: output holds between results
    a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && !out_valid) |-> $stable(out_sample));
    // R7: a full-scale positive output maps to the top code
    a_r7_dac_top: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(out_sample) >= $signed(DW'(2 ** (DW - 2)))) |-> out_dac == '1);
endmodule

// File: tb/sim_lp1_filter.sv
// Self-checking bench for lp1_filter: directed corners plus seeded random traffic.
module sim_lp1_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_sample;
    logic [7:0]  out_dac;

    int total = 0;
    int bad = 0;

    // bench model state
    int m_cff, m_cfb, m_xp, m_yp, last_y;
    bit pv0, pv1;
    int py0, py1;
    string tag;

    lp1_filter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample), .out_dac(out_dac)
    );

    always #5 clk = ~clk;

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int dac_of(input int y);
        int t;
        t = (y >>> 6) + 128;
        if (t < 0) return 0;
        if (t > 255) return 255;
        return t;
    endfunction

    function automatic int s16(input logic [15:0] v);
        return int'($signed(v));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // one cycle: check outputs of the strobe two cycles back, then drive this cycle
    task automatic tick(input bit v, input int x, input bit we, input bit sel, input int wd);
        int s, y;
        @(negedge clk);
        chk(out_valid == pv1, "R6 out_valid", int'(out_valid), int'(pv1));
        if (pv1) begin
            chk(s16(out_sample) == py1, tag, s16(out_sample), py1);
            chk(int'(out_dac) == dac_of(py1), "R7 dac", int'(out_dac), dac_of(py1));
            last_y = py1;
        end else begin
            chk(s16(out_sample) == last_y, "R5 hold", s16(out_sample), last_y);
        end
        pv1 = pv0;
        py1 = py0;
        if (we) begin
            if (sel) m_cfb = s16(16'(wd)); else m_cff = s16(16'(wd));
        end
        pv0 = v;
        if (v) begin
            s = sat16(x + m_xp);
            y = sat16(((m_cff * s) >>> 14) + ((m_cfb * m_yp) >>> 14));
            m_xp = x;
            m_yp = y;
            py0 = y;
        end
        cfg_we = we;
        cfg_sel = sel;
        cfg_wdata = 16'(wd);
        in_valid = v;
        in_sample = 16'(x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cff = 0; m_cfb = 0; m_xp = 0; m_yp = 0; last_y = 0;
        pv0 = 0; pv1 = 0; py0 = 0; py1 = 0;
    endtask

    task automatic set_coefs(input int cff, input int cfb);
        tick(0, 0, 1, 0, cff);
        tick(0, 0, 1, 1, cfb);
        tick(0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (1500000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        tag = "R2 value";
        do_reset();

        // R1: reset state at the ports
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(out_sample == 16'd0, "R1 sample", s16(out_sample), 0);
        chk(out_dac == 8'd128, "R1 dac", int'(out_dac), 128);
        // R1: coefficients cleared, a sample gives zero
        tag = "R1 zero coefs";
        tick(1, 12000, 0, 0, 0);
        idle(3);

        // R8 / R1 / R9: first sample after reset uses zero history
        do_reset();
        tag = "R8 R1 first sample";
        set_coefs(250, 15885);
        tick(1, 1000, 0, 0, 0);
        idle(3);

        // R10: DC step settles near the input
        tag = "R10 step";
        for (int i = 0; i < 600; i++) tick(1, 8192, 0, 0, 0);
        idle(3);
        chk((last_y - 8192) <= 64 && (8192 - last_y) <= 64, "R10 dc gain", last_y, 8192);

        // R10: Nyquist-rate input is removed
        tag = "R10 nyquist";
        for (int i = 0; i < 600; i++) tick(1, (i % 2) ? -8192 : 8192, 0, 0, 0);
        idle(3);
        chk(last_y <= 64 && last_y >= -64, "R10 stopband", last_y, 0);

        // R5: idle gaps between samples leave history alone
        tag = "R5 gaps";
        for (int i = 0; i < 20; i++) begin
            tick(1, 3000 - i * 400, 0, 0, 0);
            idle(1 + (i % 4));
        end

        // R3: full-scale pairs with half-scale feed-forward, no feedback
        do_reset();
        tag = "R3 sum clamp";
        set_coefs(8192, 0);
        tick(1, 32767, 0, 0, 0);
        tick(1, 32767, 0, 0, 0);
        idle(3);
        chk(last_y == 16383, "R3 positive clamp", last_y, 16383);
        tick(1, -32768, 0, 0, 0);
        tick(1, -32768, 0, 0, 0);
        idle(3);
        chk(last_y == -16384, "R3 negative clamp", last_y, -16384);

        // R4 / R7: output clamp at both rails with DAC extremes
        do_reset();
        tag = "R4 out clamp";
        set_coefs(32767, 32767);
        for (int i = 0; i < 6; i++) tick(1, 20000, 0, 0, 0);
        idle(3);
        chk(last_y == 32767, "R4 top rail", last_y, 32767);
        chk(out_dac == 8'd255, "R7 top code", int'(out_dac), 255);
        for (int i = 0; i < 10; i++) tick(1, -32768, 0, 0, 0);
        idle(3);
        chk(last_y == -32768, "R4 bottom rail", last_y, -32768);
        chk(out_dac == 8'd0, "R7 bottom code", int'(out_dac), 0);

        // R9: reset mid-stream clears history
        tick(1, 5000, 0, 0, 0);
        do_reset();
        tag = "R9 reset history";
        set_coefs(16384, 16384);
        tick(1, 4000, 0, 0, 0);
        idle(3);
        chk(last_y == 4000, "R9 first after reset", last_y, 4000);

        // R2 / R6 / R8: random strobes, data and overlapping coefficient writes
        tag = "R2 random";
        for (int i = 0; i < 4000; i++) begin
            bit v, we, sel;
            int x, wd;
            v   = ($urandom % 4) != 0;
            we  = ($urandom % 16) == 0;
            sel = 1'($urandom % 2);
            x   = s16(16'($urandom));
            wd  = sel ? (int'($urandom % 32768) - 16384) : s16(16'($urandom));
            tick(v, x, we, sel, wd);
        end
        idle(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule